// File: doc/BRIEF.md
# Packed Single-Precision Add/Subtract Unit

The unit takes two 128-bit operands, A and B. Each operand holds four 32-bit IEEE-754 single-precision elements, numbered 1 to 4 from bit 0 upward, so element k sits in bits [32k-1:32k-32]. A 3-bit operation code selects one of several packed forms. The forms are lane-wise addition, alternating subtract/add, horizontal pair addition and horizontal pair subtraction, plus two moves that duplicate elements of A. The adding forms differ only in which source elements reach each of the four lane adders, and in whether the second input of each adder is negated.

A steering stage picks the two adder inputs and the negate flag for every lane from the operation code. Four floating-point adders then work in parallel. Each one rounds to nearest-even, flushes denormals to zero and gives a canonical quiet NaN for invalid cases. A final per-lane select chooses the adder result, a raw copied element or zero. The result is captured in a single output register, and a valid flag follows the input strobe by one cycle.

Top module: `vec_fadd_unit`

## Requirements
- R1: With code 0, result element k is A element k plus B element k, for each k from 1 to 4.
- R2: With code 1, result elements 1 and 3 are A minus B and result elements 2 and 4 are A plus B, each taken lane by lane.
- R3: With code 2, the result elements 1 to 4 are A1+A2, A3+A4, B1+B2 and B3+B4.
- R4: With code 3, the result elements 1 to 4 are A1−A2, A3−A4, B1−B2 and B3−B4. In each pair the higher-numbered element is subtracted from the lower-numbered one.
- R5: With code 4, the result is {A2, A2, A4, A4} for elements 1 to 4. The bit patterns are copied unchanged and B has no effect.
- R6: With code 5, the result is {A1, A1, A3, A3} for elements 1 to 4. The bit patterns are copied unchanged and B has no effect.
- R7: Codes 6 and 7 produce an all-zero result.
- R8: Sums are rounded to nearest, with ties to the even significand.
- R9: An input with a zero exponent field counts as a zero of its own sign. A result below the smallest normal magnitude becomes a zero of the result's sign. An exact cancellation gives +0, and the sum of two zeros is −0 only when both are −0.
- R10: A NaN on either adder input gives 0x7FC00000. So does a sum of opposite-signed infinities, taken after the negation of the second input. An infinity plus a finite value returns that infinity.
- R11: out_valid is high in exactly the cycle after a cycle with in_valid high. out_data changes only after a valid input and otherwise holds its value.
- R12: While rst is high at a clock edge, out_valid and out_data are cleared to zero.
- R13: A rounded magnitude beyond the largest finite value becomes an infinity of the result's sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid in this cycle |
| in_op | input | 3 | Operation code (0 to 5 defined) |
| in_a | input | 128 | Operand A, four packed single-precision elements |
| in_b | input | 128 | Operand B, four packed single-precision elements |
| out_valid | output | 1 | Result register was loaded in the previous cycle |
| out_data | output | 128 | Registered packed result |

## Verification
The bench builds the unit with its default format parameters: an 8-bit exponent and a 23-bit fraction. This makes each lane exact IEEE single precision, so the expected values can be written as plain 32-bit hex patterns. These defaults bring several edge cases within reach of hand-chosen operands. They include ties at the 24-bit significand boundary, a difference that leaves a single bit after a 24-place normalization, sums that overflow past exponent 254, and the flush point at exponent 1.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

    localparam int NUM_LANES = 4;

    typedef enum logic [2:0] {
        OP_ADD      = 3'd0,
        OP_ALT      = 3'd1,
        OP_HADD     = 3'd2,
        OP_HSUB     = 3'd3,
        OP_DUP_ODD  = 3'd4,
        OP_DUP_EVEN = 3'd5
    } vfa_op_e;

    // Per-lane steering: where the two adder inputs come from and how the
    // lane result is formed.
    typedef struct packed {
        logic       x_from_b;
        logic [1:0] x_idx;
        logic       y_from_b;
        logic [1:0] y_idx;
        logic       negate_y;
        logic       bypass;     // lane result is the raw x element
        logic       zero;       // lane result is forced to zero
    } lane_ctl_t;

    function automatic lane_ctl_t lane_ctl(input logic [2:0] op, input int lane);
        lane_ctl_t c;
        c.x_from_b = 1'b0;
        c.x_idx    = 2'(lane);
        c.y_from_b = 1'b1;
        c.y_idx    = 2'(lane);
        c.negate_y = 1'b0;
        c.bypass   = 1'b0;
        c.zero     = 1'b0;
        case (op)
            OP_ADD: ;
            OP_ALT:
                c.negate_y = (lane % 2 == 0);
            OP_HADD, OP_HSUB: begin
                c.x_from_b = (lane >= 2);
                c.y_from_b = (lane >= 2);
                c.x_idx    = 2'((lane % 2) * 2);
                c.y_idx    = 2'((lane % 2) * 2 + 1);
                c.negate_y = (op == OP_HSUB);
            end
            OP_DUP_ODD: begin
                c.bypass = 1'b1;
                c.x_idx  = 2'((lane / 2) * 2 + 1);
            end
            OP_DUP_EVEN: begin
                c.bypass = 1'b1;
                c.x_idx  = 2'((lane / 2) * 2);
            end
            default:
                c.zero = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vfa_route.sv
module vfa_route
    import vfa_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [2:0]                         op,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]   src_a,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]   src_b,
    output logic [NUM_LANES-1:0][LANE_W-1:0]   opnd_x,
    output logic [NUM_LANES-1:0][LANE_W-1:0]   opnd_y,
    output lane_ctl_t [NUM_LANES-1:0]          ctl
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_ctl_t c;
        assign c         = lane_ctl(op, g);
        assign ctl[g]    = c;
        assign opnd_x[g] = c.x_from_b ? src_b[c.x_idx] : src_a[c.x_idx];
        assign opnd_y[g] = c.y_from_b ? src_b[c.y_idx] : src_a[c.y_idx];
    end

endmodule

// File: rtl/vfa_fadd.sv
module vfa_fadd #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_x,
    input  logic [EXP_W+FRAC_W:0] opnd_y,
    input  logic                  negate_y,
    output logic [EXP_W+FRAC_W:0] sum
);

    localparam int MANT_W = FRAC_W + 1;
    localparam int EXT_W  = MANT_W + 3;          // guard, round, sticky
    localparam int SUM_W  = EXT_W + 1;
    localparam int EXPS_W = EXP_W + 2;
    localparam int LZ_W   = $clog2(EXT_W) + 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic signed [EXPS_W-1:0] EXP_ONE  = 1;
    localparam logic signed [EXPS_W-1:0] EXP_NONE = 0;
    localparam logic signed [EXPS_W-1:0] EXP_TOP  = EMAX;
    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic               sx, sy;
    logic [EXP_W-1:0]   ex, ey;
    logic [FRAC_W-1:0]  fx, fy;
    logic               x_zero, y_zero, x_inf, y_inf, x_nan, y_nan;

    assign {sx, ex, fx} = opnd_x;
    assign sy = opnd_y[EXP_W+FRAC_W] ^ negate_y;
    assign ey = opnd_y[EXP_W+FRAC_W-1:FRAC_W];
    assign fy = opnd_y[FRAC_W-1:0];

    assign x_zero = (ex == '0);
    assign y_zero = (ey == '0);
    assign x_inf  = (&ex) && (fx == '0);
    assign y_inf  = (&ey) && (fy == '0);
    assign x_nan  = (&ex) && (fx != '0);
    assign y_nan  = (&ey) && (fy != '0);

    logic                      x_big, big_s, small_s, sticky, lz_done, rnd_up;
    logic [EXP_W-1:0]          big_e, small_e, e_diff;
    logic [EXT_W-1:0]          big_ext, small_ext, small_sh, diff, norm;
    logic [SUM_W-1:0]          raw;
    logic [LZ_W-1:0]           lz;
    logic signed [EXPS_W-1:0]  exp_n, exp_r;
    logic [FRAC_W:0]           frac_sum;
    logic [EXP_W+FRAC_W:0]     mag_res;

    // Finite, nonzero operands: align, add or subtract, normalize, round.
    always_comb begin
        x_big     = {ex, fx} >= {ey, fy};
        big_s     = x_big ? sx : sy;
        small_s   = x_big ? sy : sx;
        big_e     = x_big ? ex : ey;
        small_e   = x_big ? ey : ex;
        big_ext   = {1'b1, (x_big ? fx : fy), 3'b000};
        small_ext = {1'b1, (x_big ? fy : fx), 3'b000};
        e_diff    = big_e - small_e;

        if (32'(e_diff) >= EXT_W) begin
            small_sh = '0;
            sticky   = 1'b1;
        end else begin
            small_sh = small_ext >> e_diff;
            sticky   = |(small_ext & ~({EXT_W{1'b1}} << e_diff));
        end
        small_sh[0] = small_sh[0] | sticky;

        raw     = '0;
        diff    = '0;
        lz      = '0;
        lz_done = 1'b0;
        if (big_s == small_s) begin
            raw = {1'b0, big_ext} + {1'b0, small_sh};
            if (raw[SUM_W-1]) begin
                norm  = {raw[SUM_W-1:2], raw[1] | raw[0]};
                exp_n = $signed({2'b00, big_e}) + EXP_ONE;
            end else begin
                norm  = raw[EXT_W-1:0];
                exp_n = $signed({2'b00, big_e});
            end
        end else begin
            diff = big_ext - small_sh;
            for (int i = EXT_W - 1; i >= 0; i--) begin
                if (!lz_done) begin
                    if (diff[i]) lz_done = 1'b1;
                    else         lz = lz + LZ_W'(1);
                end
            end
            norm  = diff << lz;
            exp_n = $signed({2'b00, big_e}) - $signed(EXPS_W'(lz));
        end

        rnd_up   = norm[2] & (norm[3] | norm[1] | norm[0]);
        frac_sum = {1'b0, norm[EXT_W-2:3]} + {{FRAC_W{1'b0}}, rnd_up};
        exp_r    = exp_n + $signed({{(EXPS_W-1){1'b0}}, frac_sum[FRAC_W]});

        if (!norm[EXT_W-1])
            mag_res = '0;                                           // exact cancellation
        else if (exp_r <= EXP_NONE)
            mag_res = {big_s, {(EXP_W+FRAC_W){1'b0}}};              // flush to zero
        else if (exp_r >= EXP_TOP)
            mag_res = {big_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};       // overflow
        else
            mag_res = {big_s, exp_r[EXP_W-1:0], frac_sum[FRAC_W-1:0]};
    end

    // Special operands take priority over the magnitude path.
    always_comb begin
        if (x_nan || y_nan)
            sum = QNAN;
        else if (x_inf && y_inf && (sx != sy))
            sum = QNAN;
        else if (x_inf)
            sum = {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (y_inf)
            sum = {sy, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (x_zero && y_zero)
            sum = {sx & sy, {(EXP_W+FRAC_W){1'b0}}};
        else if (x_zero)
            sum = {sy, ey, fy};
        else if (y_zero)
            sum = {sx, ex, fx};
        else
            sum = mag_res;
    end

endmodule

// File: rtl/vec_fadd_unit.sv
module vec_fadd_unit
    import vfa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int LANE_W = 1 + EXP_W + FRAC_W,
    localparam int DATA_W = NUM_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [LANE_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [NUM_LANES-1:0][LANE_W-1:0] a_l, b_l, x_l, y_l, s_l, r_l;
    lane_ctl_t [NUM_LANES-1:0]        ctl;

    assign a_l = in_a;
    assign b_l = in_b;

    vfa_route #(.LANE_W(LANE_W)) u_route (
        .op     (in_op),
        .src_a  (a_l),
        .src_b  (b_l),
        .opnd_x (x_l),
        .opnd_y (y_l),
        .ctl    (ctl)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_add
        vfa_fadd #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fadd (
            .opnd_x   (x_l[g]),
            .opnd_y   (y_l[g]),
            .negate_y (ctl[g].negate_y),
            .sum      (s_l[g])
        );
        assign r_l[g] = ctl[g].zero   ? '0      :
                        ctl[g].bypass ? x_l[g]  : s_l[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= r_l;
        end
    end

    // Output stage timing and hold
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r11_data_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // Lane steering outcomes
    a_r7_undefined_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 3'd5) |=> out_data == '0);
    a_r5_odd_dup: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4) |=>
            (out_data[LANE_W-1:0] == $past(in_a[2*LANE_W-1:LANE_W]) &&
             out_data[2*LANE_W-1:LANE_W] == $past(in_a[2*LANE_W-1:LANE_W])));
    a_r6_even_dup: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd5) |=>
            (out_data[4*LANE_W-1:3*LANE_W] == $past(in_a[3*LANE_W-1:2*LANE_W])));
    a_r10_nan_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0 && (&in_a[LANE_W-2:FRAC_W]) && (|in_a[FRAC_W-1:0]))
            |=> out_data[LANE_W-1:0] == QNAN);

endmodule

// File: tb/test_vec_fadd_unit.sv
module test_vec_fadd_unit;

    localparam int NV = 15;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   in_op;
    logic [127:0] in_a, in_b;
    logic         out_valid;
    logic [127:0] out_data;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vec_fadd_unit i_vec_fadd_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Elements listed element4_element3_element2_element1.
    localparam logic [2:0] V_OP [NV] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
        3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd1 };
    localparam int V_REQ [NV] = '{
        1, 2, 3, 4, 5, 6, 7, 7, 1, 8, 9, 10, 13, 4, 2 };
    localparam logic [127:0] V_A [NV] = '{
        128'h40800000_40400000_40000000_3F800000,   // R1 lane-wise add
        128'h40800000_40400000_40000000_3F800000,   // R2 alternating
        128'h40800000_40400000_40000000_3F800000,   // R3 horizontal add
        128'h40800000_40400000_40000000_3F800000,   // R4 horizontal sub
        128'h40800000_40400000_40000000_3F800000,   // R5 odd duplicate
        128'h40800000_40400000_40000000_3F800000,   // R6 even duplicate
        128'h40800000_40400000_40000000_3F800000,   // R7 code 6
        128'h40800000_40400000_40000000_3F800000,   // R7 code 7
        128'h3E800000_BF800000_3FC00000_3F000000,   // R1 signs, cancel
        128'h3F800000_3F800000_3F800001_3F800000,   // R8 ties and sticky
        128'h80400000_80C00000_80400000_00400000,   // R9 flush to zero
        128'h7F800000_7F800000_FFFFFFFF_7F800001,   // R10 NaN and infinities
        128'h7F7FFFFF_FF800000_FF7FFFFF_7F7FFFFF,   // R13 overflow
        128'hBF800000_3F800000_7F800000_7F800000,   // R4 R10 inf minus inf
        128'h40000000_3F800000_40400000_3F800000 }; // R2 cancellation
    localparam logic [127:0] V_B [NV] = '{
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'h41000000_40E00000_40C00000_40A00000,
        128'hC0000000_3F800000_BFC00000_3F000000,
        128'h33000000_33C00000_33800000_33800000,
        128'h80000000_00800000_00000000_3F800000,
        128'h3F800000_FF800000_3F800000_3F800000,
        128'h3F800000_40A00000_FF7FFFFF_7F7FFFFF,
        128'h3F800000_00000000_41200000_40A00000,
        128'h3F800000_3F7FFFFF_C0400000_3F800000 };
    localparam logic [127:0] V_E [NV] = '{
        128'h41400000_41200000_41000000_40C00000,
        128'h41400000_C0800000_41000000_C0800000,
        128'h41700000_41300000_40E00000_40400000,
        128'hBF800000_BF800000_BF800000_BF800000,
        128'h40800000_40800000_40000000_40000000,
        128'h40400000_40400000_3F800000_3F800000,
        128'h00000000_00000000_00000000_00000000,
        128'h00000000_00000000_00000000_00000000,
        128'hBFE00000_00000000_00000000_3F800000,
        128'h3F800000_3F800001_3F800002_3F800000,
        128'h80000000_80000000_00000000_3F800000,
        128'h7F800000_7FC00000_7FC00000_7FC00000,
        128'h7F7FFFFF_FF800000_FF800000_7F800000,
        128'hBF800000_C0A00000_40000000_7FC00000,
        128'h40400000_33800000_00000000_00000000 };

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R11 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [127:0] last;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_op    = 3'd0;
        in_a     = '0;
        in_b     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "reset out_valid", {127'd0, out_valid}, 128'd0);
        check("R12", "reset out_data", out_data, 128'd0);
        rst = 1'b0;

        // Table walk, back to back
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_op    = V_OP[i];
            in_a     = V_A[i];
            in_b     = V_B[i];
            @(negedge clk);
            check("R11", "out_valid after input", {127'd0, out_valid}, 128'd1);
            check($sformatf("R%0d", V_REQ[i]), $sformatf("vector %0d", i),
                  out_data, V_E[i]);
        end
        last = V_E[NV-1];

        // R11: idle inputs do not disturb the held result
        in_valid = 1'b0;
        in_op    = 3'd0;
        in_a     = 128'h3F800000_3F800000_3F800000_3F800000;
        in_b     = 128'h3F800000_3F800000_3F800000_3F800000;
        @(negedge clk);
        check("R11", "out_valid drops", {127'd0, out_valid}, 128'd0);
        check("R11", "data held", out_data, last);
        repeat (3) @(negedge clk);
        check("R11", "data still held", out_data, last);

        // R12: reset in mid-run clears the held result
        rst = 1'b1;
        @(negedge clk);
        check("R12", "mid reset out_data", out_data, 128'd0);
        check("R12", "mid reset out_valid", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        // R11: single pulse after idle
        in_valid = 1'b1;
        in_op    = V_OP[2];
        in_a     = V_A[2];
        in_b     = V_B[2];
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "pulse valid", {127'd0, out_valid}, 128'd1);
        check("R3", "pulse data", out_data, V_E[2]);
        @(negedge clk);
        check("R11", "pulse valid one cycle", {127'd0, out_valid}, 128'd0);

        // R5: NaN patterns are copied raw by the odd duplicate
        in_valid = 1'b1;
        in_op    = 3'd4;
        in_a     = 128'h7F800001_00000000_FFC12345_00000000;
        in_b     = '1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5", "raw NaN copy", out_data,
              128'h7F800001_7F800001_FFC12345_FFC12345);

        @(negedge clk);
        finish_run();
    end

endmodule